// File: doc/BRIEF.md
# Dual-Bank Event List Recorder

The recorder stores detector events in one of two memory banks. Each event is a 12-bit energy and a 20-bit arrival time. One bank takes events while the other stays frozen, so a host can drain the frozen bank at its own pace and then swap roles with a single select bit. No event is lost as long as the host empties a bank before the other one fills.

Word 0 of each bank is a header. The header reports how many event words are valid and which time-stamp resolution was in force when they were written. The time stamps come from a 20-bit wall clock. This clock is advanced by a free-running prescaler whose tick period is a power of two, chosen at run time. Separate strobes clear a bank's event count and the wall clock. Each bank has its own read port, which returns any word one cycle after the address is presented.

Top module: `evlist_rec`

## Requirements
- R1: After reset, both bank headers read as zero and the wall clock starts from zero.
- R2: Each bank holds 512 words of 32 bits. Address 0 is the header and addresses 1 to 511 hold events in arrival order: the k-th accepted event since the count was last cleared lands at address k. The header carries the valid count in bits [11:0], the resolution exponent in bits [15:12], and zero in bits [31:16].
- R3: An event word carries the energy in bits [31:20] and the arrival time stamp in bits [19:0].
- R4: With exponent x (0..15) held constant, an event presented in a cycle that follows n clock edges since reset or since the last clock-clear strobe is stamped with floor(n / 2^x) mod 2^20.
- R5: The clock-clear strobe resets both the prescaler and the time counter at the next edge. An event in that same cycle still carries the value from before the clear.
- R6: The event is written to the bank named by the select bit in that same cycle (0 selects bank 0, 1 selects bank 1). This applies even in the cycle where the select bit changes. The other bank's header and words stay unchanged.
- R7: The count-clear strobe sets the count of the selected bank to zero and leaves its stored event words readable and unchanged.
- R8: A count-clear and an event in the same cycle give a count of 1, with that event stored at address 1.
- R9: Once a bank holds 511 events, further events to it are dropped. Its count stays at 511 and its words are not overwritten.
- R10: The header exponent field is the exponent sampled with the most recent accepted event. Dropped events do not change it.
- R11: Read data shows the addressed word one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event strobe, one cycle per event |
| ev_energy | input | 12 | Energy of the strobed event |
| bank_sel | input | 1 | Selects the acquiring bank |
| tick_exp | input | 4 | Time-stamp resolution exponent x |
| clr_count | input | 1 | Clears the selected bank's event count |
| clr_time | input | 1 | Clears prescaler and wall clock |
| rd_addr0 | input | 9 | Read address, bank 0 |
| rd_data0 | output | 32 | Read data, bank 0 |
| rd_addr1 | input | 9 | Read address, bank 1 |
| rd_data1 | output | 32 | Read data, bank 1 |

## Verification
Two pairs of functions can act in the same cycle. The first pair is an event and a count clear on the same bank. The second is an event and a wall-clock clear. The bench provokes both by raising the strobes together. It then judges by reading back the header count and the word at address 1, and by comparing the stamp with the pre-clear cycle count computed in the bench. A select-bit change together with an event is also driven, and both banks are read back in full to show where the event landed.

// File: rtl/evrec_pkg.sv
package evrec_pkg;
  parameter int ENERGY_W = 12;
  parameter int TIME_W   = 20;
  parameter int ADDR_W   = 9;
  parameter int EXP_W    = 4;
  parameter int CNT_W    = 12;
  localparam int DATA_W  = ENERGY_W + TIME_W;

  function automatic logic [DATA_W-1:0] pack_event(
    input logic [ENERGY_W-1:0] energy,
    input logic [TIME_W-1:0]   stamp
  );
    return {energy, stamp};
  endfunction
endpackage

// File: rtl/evrec_timebase.sv
module evrec_timebase #(
  parameter int EXP_W  = 4,
  parameter int TIME_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [EXP_W-1:0]  exp_sel,
  output logic [TIME_W-1:0] stamp
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [TIME_W-1:0] time_q, time_n;
  logic [PRE_W-1:0]  mask;
  logic              tick;

  always_comb begin
    mask   = ~({PRE_W{1'b1}} << exp_sel);
    tick   = ((pre_q & mask) == mask);
    pre_n  = pre_q + 1'b1;
    time_n = time_q;
    if (tick) time_n = time_q + 1'b1;
    if (clr) begin
      pre_n  = '0;
      time_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      time_q <= '0;
    end else begin
      pre_q  <= pre_n;
      time_q <= time_n;
    end
  end

  assign stamp = time_q;

  AST_TIME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (time_q == '0) && (pre_q == '0)); // R5
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (time_q == $past(time_q)) || (time_q == TIME_W'($past(time_q) + 1'b1))); // R4
endmodule

// File: rtl/evrec_bank.sv
module evrec_bank #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [EXP_W-1:0]  wr_exp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam int PAD_W = DATA_W - EXP_W - CNT_W;

  logic [ADDR_W-1:0] cnt_q, cnt_n;
  logic [EXP_W-1:0]  exp_q, exp_n;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic [DATA_W-1:0] header;
  logic [DATA_W-1:0] rd_n;

  always_comb begin
    cnt_n  = cnt_q;
    exp_n  = exp_q;
    mem_we = 1'b0;
    mem_wa = cnt_q + 1'b1;
    if (clr_en) begin
      cnt_n  = '0;
      mem_wa = ADDR_W'(1);
      if (wr_en) begin
        cnt_n  = ADDR_W'(1);
        mem_we = 1'b1;
        exp_n  = wr_exp;
      end
    end else if (wr_en && (cnt_q != LAST)) begin
      cnt_n  = cnt_q + 1'b1;
      mem_we = 1'b1;
      exp_n  = wr_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      exp_q <= exp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= wr_word;
  end

  always_comb begin
    header = {{PAD_W{1'b0}}, exp_q, {(CNT_W-ADDR_W){1'b0}}, cnt_q};
    rd_n   = (rd_addr == '0) ? header : mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_n;
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en && cnt_q == LAST) |=> (cnt_q == LAST) && $stable(exp_q)); // R9
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> (cnt_q == '0)); // R7
  AST_CLR_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && wr_en) |=> (cnt_q == ADDR_W'(1))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_en) |=> $stable(cnt_q) && $stable(exp_q)); // R6
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en && cnt_q != LAST) |=> (cnt_q == ADDR_W'($past(cnt_q) + 1'b1))); // R2
endmodule

// File: rtl/evlist_rec.sv
module evlist_rec
  import evrec_pkg::*;
#(
  parameter int P_ENERGY_W = ENERGY_W,
  parameter int P_TIME_W   = TIME_W,
  parameter int P_ADDR_W   = ADDR_W,
  parameter int P_EXP_W    = EXP_W,
  parameter int P_CNT_W    = CNT_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ev_valid,
  input  logic [P_ENERGY_W-1:0]            ev_energy,
  input  logic                             bank_sel,
  input  logic [P_EXP_W-1:0]               tick_exp,
  input  logic                             clr_count,
  input  logic                             clr_time,
  input  logic [P_ADDR_W-1:0]              rd_addr0,
  output logic [P_ENERGY_W+P_TIME_W-1:0]   rd_data0,
  input  logic [P_ADDR_W-1:0]              rd_addr1,
  output logic [P_ENERGY_W+P_TIME_W-1:0]   rd_data1
);
  localparam int P_DATA_W = P_ENERGY_W + P_TIME_W;
  localparam int N_BANKS  = 2;

  logic [P_TIME_W-1:0] stamp;
  logic [P_DATA_W-1:0] word;
  logic [P_ADDR_W-1:0] rd_addr [N_BANKS];
  logic [P_DATA_W-1:0] rd_data [N_BANKS];

  evrec_timebase #(.EXP_W(P_EXP_W), .TIME_W(P_TIME_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_time),
    .exp_sel (tick_exp),
    .stamp   (stamp)
  );

  assign word       = {ev_energy, stamp};
  assign rd_addr[0] = rd_addr0;
  assign rd_addr[1] = rd_addr1;
  assign rd_data0   = rd_data[0];
  assign rd_data1   = rd_data[1];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic sel_b;
    assign sel_b = (bank_sel == 1'(b));
    evrec_bank #(
      .ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W), .EXP_W(P_EXP_W), .CNT_W(P_CNT_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ev_valid && sel_b),
      .clr_en  (clr_count && sel_b),
      .wr_word (word),
      .wr_exp  (tick_exp),
      .rd_addr (rd_addr[b]),
      .rd_data (rd_data[b])
    );
  end
endmodule

// File: tb/sim_evlist_rec.sv
module sim_evlist_rec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, bank_sel, clr_count, clr_time;
  logic [11:0] ev_energy;
  logic [3:0]  tick_exp;
  logic [8:0]  rd_addr0, rd_addr1;
  logic [31:0] rd_data0, rd_data1;

  always #2 clk = ~clk;

  evlist_rec u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_energy(ev_energy),
    .bank_sel(bank_sel), .tick_exp(tick_exp), .clr_count(clr_count),
    .clr_time(clr_time), .rd_addr0(rd_addr0), .rd_data0(rd_data0),
    .rd_addr1(rd_addr1), .rd_data1(rd_data1)
  );

  int n_edges;
  always @(posedge clk) begin
    if (!rst_n || clr_time) n_edges <= 0;
    else                    n_edges <= n_edges + 1;
  end

  logic [31:0] m_mem [2][512];
  int m_cnt [2];
  int m_x   [2];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // R11: address applied at a falling edge, data sampled one rising edge later
  task automatic rd(input int b, input int a, output logic [31:0] d);
    @(negedge clk);
    if (b == 0) rd_addr0 = 9'(a); else rd_addr1 = 9'(a);
    @(negedge clk);
    d = (b == 0) ? rd_data0 : rd_data1;
  endtask

  task automatic pulse(input bit sel, input bit val, input logic [11:0] e,
                       input bit clrc, input bit clrt);
    logic [19:0] st;
    bank_sel  = sel;
    ev_valid  = val;
    ev_energy = e;
    clr_count = clrc;
    clr_time  = clrt;
    st = 20'((n_edges >> tick_exp) & 32'hFFFFF);
    if (clrc) m_cnt[sel] = 0;
    if (val && m_cnt[sel] < 511) begin
      m_cnt[sel]++;
      m_mem[sel][m_cnt[sel]] = {e, st};
      m_x[sel] = int'(tick_exp);
    end
    @(negedge clk);
    ev_valid  = 1'b0;
    clr_count = 1'b0;
    clr_time  = 1'b0;
  endtask

  task automatic verify(input int b, input string req);
    logic [31:0] d;
    rd(b, 0, d);
    chk({req, "/R2 header"}, d, {16'h0, 4'(m_x[b]), 12'(m_cnt[b])});
    for (int a = 1; a <= m_cnt[b]; a++) begin
      rd(b, a, d);
      chk({req, "/R3 word"}, d, m_mem[b][a]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; ev_valid = 0; bank_sel = 0; clr_count = 0; clr_time = 0;
    ev_energy = '0; tick_exp = '0; rd_addr0 = '0; rd_addr1 = '0;
    for (int b = 0; b < 2; b++) begin m_cnt[b] = 0; m_x[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of both headers
    verify(0, "R1");
    verify(1, "R1");

    // R4, R3, R10: sweep every exponent on bank 0
    for (int x = 0; x < 16; x++) begin
      @(negedge clk);
      tick_exp = 4'(x);
      pulse(1'b0, 1'b0, 12'h0, 1'b0, 1'b1);
      repeat ((1 << x) + 5 * x) @(negedge clk);
      pulse(1'b0, 1'b1, 12'((x * 257) ^ 12'h5A3), 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      pulse(1'b0, 1'b1, 12'(x * 13 + 1), 1'b0, 1'b0);
    end
    verify(0, "R4");

    // R6: select change and event in the same cycle, then back-to-back events
    @(negedge clk);
    tick_exp = 4'd2;
    pulse(1'b0, 1'b0, 12'h0, 1'b0, 1'b1);
    repeat (9) @(negedge clk);
    pulse(1'b1, 1'b1, 12'hABC, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) pulse(1'b1, 1'b1, 12'(i * 100 + 7), 1'b0, 1'b0);
    verify(1, "R6");
    verify(0, "R6");

    // R5: clock clear together with an event, then an event right after
    @(negedge clk);
    tick_exp = 4'd0;
    pulse(1'b1, 1'b0, 12'h0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    pulse(1'b1, 1'b1, 12'h111, 1'b0, 1'b1);
    pulse(1'b1, 1'b1, 12'h222, 1'b0, 1'b0);
    verify(1, "R5");

    // R7: count clear alone keeps stored words
    pulse(1'b1, 1'b0, 12'h0, 1'b1, 1'b0);
    rd(1, 0, d);
    chk("R7 header count", d, {16'h0, 4'(m_x[1]), 12'h000});
    for (int a = 1; a <= 9; a++) begin
      rd(1, a, d);
      chk("R7 word kept", d, m_mem[1][a]);
    end

    // R8: count clear and event in the same cycle
    pulse(1'b1, 1'b1, 12'h3C3, 1'b1, 1'b0);
    verify(1, "R8");
    rd(1, 2, d);
    chk("R8 word 2 kept", d, m_mem[1][2]);

    // R9, R10: fill bank 0 and overflow it
    pulse(1'b0, 1'b0, 12'h0, 1'b1, 1'b0);
    for (int i = 0; i < 515; i++) pulse(1'b0, 1'b1, 12'(i * 7 + 3), 1'b0, 1'b0);
    @(negedge clk);
    tick_exp = 4'd7;
    pulse(1'b0, 1'b1, 12'hFFF, 1'b0, 1'b0);
    verify(0, "R9");
    rd(0, 0, d);
    chk("R10 exponent kept on drop", d, {16'h0, 4'h0, 12'd511});
    verify(1, "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule